// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power state the chip occupies and drives the clock-enable, regulator and power-domain controls that belong to that state. It watches the core's sleep requests: a wait-for-interrupt pulse, a wait-for-event pulse and an exception-return strobe, the last of which acts only when the sleep-on-exit bit is set. At the moment of entry it samples a small set of configuration bits that select how deep the sleep goes. These bits choose between plain sleep, sleep with the flash clock gated and the regulator lowered, stop with every clock gated, and standby with the core power domain switched off.

While the core is running, the same bits also choose between full-power Run and low-power run. Low-power run keeps the CPU clocked but asks the regulator for its low-power setting. The block remembers whether a sleep was requested as interrupt-wait or event-wait, and it leaves the sleep only on the matching wake source. Standby is left only through reset. Every output is decoded from registered state, so all controls change together one clock after the request that causes them.

Top module: `lpm_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the block is in Run. In Run, the CPU, flash and peripheral clock enables are 1, the regulator low-power request is 0, the core power enable is 1 and the mode code is 0.
- R2: The mode code reports the current state as follows: Run=0, low-power run=1, sleep=2, low-power sleep=3, stop=4, standby=5.
- R3: From Run or low-power run, a wait-for-interrupt pulse causes entry. An exception-return strobe causes entry only when sleep-on-exit is 1; when sleep-on-exit is 0 the strobe has no effect. With lp-regulator, deep and standby selects all 0, the block enters sleep (code 2) on the next clock. In sleep only the CPU clock enable is 0.
- R4: A sleep-class state entered by interrupt-wait ends when any bit of the interrupt-pending vector is 1. One entered by event-wait ends only on the wakeup-event line, and pending interrupts do not end it.
- R5: With the lp-regulator select at 1 and deep select at 0 at entry, the block enters low-power sleep (code 3). In this state the CPU and flash clock enables are 0 and the regulator low-power request is 1. The select bits are sampled only at entry, so changing them during the sleep does not change the state.
- R6: In Run or low-power run, when lp-regulator select and lp-run select are both 1, the block is in low-power run (code 1) from the next clock. In this state all clocks are enabled and the regulator low-power request is 1. When either select bit is 0, the block returns to Run.
- R7: With deep select at 1 and standby select at 0 at entry, the block enters stop (code 4). In stop, all three clock enables are 0, the regulator low-power request is 1 and the core power enable is 1. The wake rules of R4 apply.
- R8: With deep select and standby select both 1 at entry, the block enters standby (code 5). In standby, all clock enables, the regulator request and the core power enable are 0. No interrupt or event leaves standby; only reset does.
- R9: An interrupt-wait request (R3) that arrives while any interrupt-pending bit is 1 is ignored, and the block stays running.
- R10: If a wait-for-interrupt pulse and a wait-for-event pulse arrive in the same cycle, the entry is an interrupt-wait entry. A wait-for-event pulse alone enters even while interrupts are pending.
- R11: On wake from sleep, low-power sleep or stop, the block returns to low-power run if both lp-regulator and lp-run selects are 1 at that time, and otherwise to Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| exc_ret | input | 1 | Exception-return strobe |
| sleep_on_exit | input | 1 | Enter sleep on exception return |
| lp_reg_sel | input | 1 | Select low-power regulator |
| lp_run_sel | input | 1 | Select low-power run while active |
| deep_sel | input | 1 | Select stop instead of sleep |
| standby_sel | input | 1 | With deep_sel, select standby |
| irq_pend | input | NIRQ | Interrupt-pending vector |
| wake_evt | input | 1 | Wakeup event line |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| reg_lp_req | output | 1 | Regulator low-power request |
| core_pwr_en | output | 1 | Core power domain enable |
| mode_code | output | 3 | Current mode code |

## Verification
Each entry path is tried on its own so that a wrong target state can be traced to one cause. The three entry triggers are used with and without sleep-on-exit. The target selection covers the sleep, low-power sleep, stop and standby choices, and the select bits are toggled in the middle of a sleep to show they were latched at entry. The wake sources are crossed with the entry kind: interrupts applied during an event-wait sleep must not wake it, and an event-wait entry while an interrupt is pending must still go to sleep. A long random phase with periodic resets then mixes the triggers with pending interrupts and select changes, which exposes errors in priority and in the return to low-power run.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_RUN     = 3'd0,
    M_LPRUN   = 3'd1,
    M_SLEEP   = 3'd2,
    M_LPSLEEP = 3'd3,
    M_STOP    = 3'd4,
    M_STANDBY = 3'd5
  } lpm_mode_e;

  typedef enum logic {
    WK_IRQ = 1'b0,
    WK_EVT = 1'b1
  } wake_kind_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic periph;
    logic reg_lp;
    logic core_pwr;
  } gate_t;
endpackage

// File: rtl/lpm_entry_decode.sv
module lpm_entry_decode
  import lpm_pkg::*;
(
  input  logic       active,
  input  logic       wfi_req,
  input  logic       wfe_req,
  input  logic       exc_ret,
  input  logic       sleep_on_exit,
  input  logic       irq_any,
  input  logic       lp_reg_sel,
  input  logic       deep_sel,
  input  logic       standby_sel,
  output logic       enter,
  output wake_kind_e kind,
  output lpm_mode_e  target
);
  logic irq_wait;

  // interrupt-wait wins over event-wait when both arrive together
  assign irq_wait = wfi_req | (exc_ret & sleep_on_exit);
  assign kind     = irq_wait ? WK_IRQ : WK_EVT;

  always_comb begin
    if (!active)       enter = 1'b0;
    else if (irq_wait) enter = !irq_any;
    else               enter = wfe_req;
  end

  always_comb begin
    if (deep_sel && standby_sel) target = M_STANDBY;
    else if (deep_sel)           target = M_STOP;
    else if (lp_reg_sel)         target = M_LPSLEEP;
    else                         target = M_SLEEP;
  end
endmodule

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect
  import lpm_pkg::*;
#(
  parameter int NIRQ = 32
) (
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            wake_evt,
  input  logic            asleep,
  input  wake_kind_e      kind,
  output logic            irq_any,
  output logic            wake
);
  assign irq_any = |irq_pend;

  always_comb begin
    if (!asleep)              wake = 1'b0;
    else if (kind == WK_IRQ)  wake = irq_any;
    else                      wake = wake_evt;
  end
endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
  import lpm_pkg::*;
(
  input  lpm_mode_e mode,
  output gate_t     gates
);
  always_comb begin
    unique case (mode)
      M_RUN:     gates = '{cpu: 1'b1, flash: 1'b1, periph: 1'b1, reg_lp: 1'b0, core_pwr: 1'b1};
      M_LPRUN:   gates = '{cpu: 1'b1, flash: 1'b1, periph: 1'b1, reg_lp: 1'b1, core_pwr: 1'b1};
      M_SLEEP:   gates = '{cpu: 1'b0, flash: 1'b1, periph: 1'b1, reg_lp: 1'b0, core_pwr: 1'b1};
      M_LPSLEEP: gates = '{cpu: 1'b0, flash: 1'b0, periph: 1'b1, reg_lp: 1'b1, core_pwr: 1'b1};
      M_STOP:    gates = '{cpu: 1'b0, flash: 1'b0, periph: 1'b0, reg_lp: 1'b1, core_pwr: 1'b1};
      M_STANDBY: gates = '{cpu: 1'b0, flash: 1'b0, periph: 1'b0, reg_lp: 1'b0, core_pwr: 1'b0};
      default:   gates = '{cpu: 1'b1, flash: 1'b1, periph: 1'b1, reg_lp: 1'b0, core_pwr: 1'b1};
    endcase
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi_req,
  input  logic            wfe_req,
  input  logic            exc_ret,
  input  logic            sleep_on_exit,
  input  logic            lp_reg_sel,
  input  logic            lp_run_sel,
  input  logic            deep_sel,
  input  logic            standby_sel,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            wake_evt,
  output logic            cpu_clk_en,
  output logic            flash_clk_en,
  output logic            periph_clk_en,
  output logic            reg_lp_req,
  output logic            core_pwr_en,
  output logic [2:0]      mode_code
);
  lpm_mode_e  mode_q, mode_d, target, run_mode;
  wake_kind_e kind_q, kind_d, ent_kind;
  logic       active, asleep, enter, wake, irq_any;
  gate_t      gates;

  assign active   = (mode_q == M_RUN) || (mode_q == M_LPRUN);
  assign asleep   = (mode_q == M_SLEEP) || (mode_q == M_LPSLEEP) || (mode_q == M_STOP);
  assign run_mode = (lp_reg_sel && lp_run_sel) ? M_LPRUN : M_RUN;

  lpm_wake_detect #(.NIRQ(NIRQ)) u_wake (
    .irq_pend (irq_pend),
    .wake_evt (wake_evt),
    .asleep   (asleep),
    .kind     (kind_q),
    .irq_any  (irq_any),
    .wake     (wake)
  );

  lpm_entry_decode u_entry (
    .active        (active),
    .wfi_req       (wfi_req),
    .wfe_req       (wfe_req),
    .exc_ret       (exc_ret),
    .sleep_on_exit (sleep_on_exit),
    .irq_any       (irq_any),
    .lp_reg_sel    (lp_reg_sel),
    .deep_sel      (deep_sel),
    .standby_sel   (standby_sel),
    .enter         (enter),
    .kind          (ent_kind),
    .target        (target)
  );

  always_comb begin
    mode_d = mode_q;
    kind_d = kind_q;
    unique case (mode_q)
      M_RUN, M_LPRUN: begin
        if (enter) begin
          mode_d = target;
          kind_d = ent_kind;
        end else begin
          mode_d = run_mode;
        end
      end
      M_SLEEP, M_LPSLEEP, M_STOP: begin
        if (wake) mode_d = run_mode;
      end
      M_STANDBY: mode_d = M_STANDBY;
      default:   mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_RUN;
      kind_q <= WK_IRQ;
    end else begin
      mode_q <= mode_d;
      kind_q <= kind_d;
    end
  end

  lpm_gate_decode u_gate (
    .mode  (mode_q),
    .gates (gates)
  );

  assign cpu_clk_en    = gates.cpu;
  assign flash_clk_en  = gates.flash;
  assign periph_clk_en = gates.periph;
  assign reg_lp_req    = gates.reg_lp;
  assign core_pwr_en   = gates.core_pwr;
  assign mode_code     = mode_q;

  a_r8_standby_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STANDBY) |=> (mode_q == M_STANDBY) && !core_pwr_en);

  a_r9_wait_with_irq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    active && (wfi_req || (exc_ret && sleep_on_exit)) && (|irq_pend)
      |=> (mode_code == 3'd0) || (mode_code == 3'd1));

  a_r4_event_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && (kind_q == WK_EVT) && !wake_evt |=> $stable(mode_q));

  a_r3_sleep_cpu_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd2) |-> !cpu_clk_en && flash_clk_en && periph_clk_en && !reg_lp_req);

  a_r7_stop_all_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd4) |-> !cpu_clk_en && !flash_clk_en && !periph_clk_en && reg_lp_req && core_pwr_en);
endmodule

// File: tb/lpm_sequencer_tb.sv
`timescale 1ns/1ps
module lpm_sequencer_tb;
  localparam int NIRQ = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 0, wfe_req = 0, exc_ret = 0, sleep_on_exit = 0;
  logic lp_reg_sel = 0, lp_run_sel = 0, deep_sel = 0, standby_sel = 0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic wake_evt = 0;
  logic cpu_clk_en, flash_clk_en, periph_clk_en, reg_lp_req, core_pwr_en;
  logic [2:0] mode_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpm_sequencer #(.NIRQ(NIRQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .exc_ret(exc_ret), .sleep_on_exit(sleep_on_exit), .lp_reg_sel(lp_reg_sel),
    .lp_run_sel(lp_run_sel), .deep_sel(deep_sel), .standby_sel(standby_sel),
    .irq_pend(irq_pend), .wake_evt(wake_evt), .cpu_clk_en(cpu_clk_en),
    .flash_clk_en(flash_clk_en), .periph_clk_en(periph_clk_en),
    .reg_lp_req(reg_lp_req), .core_pwr_en(core_pwr_en), .mode_code(mode_code)
  );

  // behavioural reference: mode number and whether the sleep waits for an event
  int m_mode = 0;
  bit m_evt = 0;
  int nm;
  bit irqw, anyirq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_evt = 0;
    end else begin
      nm = m_mode;
      irqw = wfi_req || (exc_ret && sleep_on_exit);
      anyirq = (irq_pend != 0);
      if (m_mode <= 1) begin
        if ((irqw && !anyirq) || (!irqw && wfe_req)) begin
          m_evt = !irqw;
          if (deep_sel && standby_sel) nm = 5;
          else if (deep_sel) nm = 4;
          else if (lp_reg_sel) nm = 3;
          else nm = 2;
        end else begin
          nm = (lp_reg_sel && lp_run_sel) ? 1 : 0;
        end
      end else if (m_mode < 5) begin
        if (m_evt ? wake_evt : anyirq) nm = (lp_reg_sel && lp_run_sel) ? 1 : 0;
      end
      m_mode = nm;
    end
  end

  // {cpu, flash, periph, reg_lp, core_pwr} expected per mode
  function automatic logic [4:0] exp_gates(input int m);
    case (m)
      0: return 5'b11101;
      1: return 5'b11111;
      2: return 5'b01101;
      3: return 5'b00111;
      4: return 5'b00011;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R1";
      1: return "R6";
      2: return "R3";
      3: return "R5";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic compare();
    logic [4:0] act;
    act = {cpu_clk_en, flash_clk_en, periph_clk_en, reg_lp_req, core_pwr_en};
    checks++;
    if (act !== exp_gates(m_mode) || mode_code !== m_mode[2:0]) begin
      failures++;
      $display("FAIL %s/R2 t=%0t actual mode=%0d gates=%b expected mode=%0d gates=%b",
               tag_of(m_mode), $time, mode_code, act, m_mode, exp_gates(m_mode));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    wfi_req = 0; wfe_req = 0; exc_ret = 0; wake_evt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expect_mode(input logic [2:0] exp, input string tag);
    checks++;
    if (mode_code !== exp) begin
      failures++;
      $display("FAIL %s actual mode=%0d expected mode=%0d", tag, mode_code, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle(2);
    rst_n = 1;
    tick();
  endtask

  initial begin
    irq_pend = '0;
    idle(2);
    expect_mode(3'd0, "R1");
    rst_n = 1;
    idle(2);
    expect_mode(3'd0, "R1");

    // R3: plain wfi entry, R4: any irq bit wakes
    wfi_req = 1; tick(); expect_mode(3'd2, "R3");
    idle(3); expect_mode(3'd2, "R3");
    irq_pend[5] = 1; tick(); irq_pend = '0; expect_mode(3'd0, "R4");

    // R3: exception return without then with sleep-on-exit
    exc_ret = 1; tick(); expect_mode(3'd0, "R3");
    sleep_on_exit = 1; exc_ret = 1; tick(); expect_mode(3'd2, "R3");
    irq_pend[31] = 1; tick(); irq_pend = '0; sleep_on_exit = 0; expect_mode(3'd0, "R4");

    // R4: event-wait sleep ignores interrupts
    wfe_req = 1; tick(); expect_mode(3'd2, "R4");
    irq_pend[0] = 1; idle(2); irq_pend = '0; expect_mode(3'd2, "R4");
    wake_evt = 1; tick(); expect_mode(3'd0, "R4");

    // R5: low-power sleep, selects latched at entry
    lp_reg_sel = 1; wfi_req = 1; tick(); expect_mode(3'd3, "R5");
    lp_reg_sel = 0; deep_sel = 1; idle(2); expect_mode(3'd3, "R5");
    deep_sel = 0; irq_pend[7] = 1; tick(); irq_pend = '0; expect_mode(3'd0, "R4");

    // R6 and R11: low-power run, sleep from it, return to it
    lp_reg_sel = 1; lp_run_sel = 1; tick(); expect_mode(3'd1, "R6");
    wfi_req = 1; tick(); expect_mode(3'd3, "R5");
    irq_pend[2] = 1; tick(); irq_pend = '0; expect_mode(3'd1, "R11");
    lp_run_sel = 0; tick(); expect_mode(3'd0, "R6");
    lp_reg_sel = 0; tick();

    // R7: stop, event-wait, irq ignored
    deep_sel = 1; wfe_req = 1; tick(); expect_mode(3'd4, "R7");
    irq_pend[9] = 1; idle(2); irq_pend = '0; expect_mode(3'd4, "R7");
    lp_reg_sel = 1; lp_run_sel = 1;
    wake_evt = 1; tick(); expect_mode(3'd1, "R11");
    lp_reg_sel = 0; lp_run_sel = 0; deep_sel = 0; tick();

    // R9: interrupt-wait with pending irq ignored; R10: event-wait still enters
    irq_pend[3] = 1; wfi_req = 1; tick(); expect_mode(3'd0, "R9");
    sleep_on_exit = 1; exc_ret = 1; tick(); expect_mode(3'd0, "R9");
    sleep_on_exit = 0;
    wfe_req = 1; tick(); expect_mode(3'd2, "R10");
    idle(2); expect_mode(3'd2, "R10");
    irq_pend = '0; wake_evt = 1; tick(); expect_mode(3'd0, "R10");

    // R10: both pulses together form an interrupt-wait entry
    wfi_req = 1; wfe_req = 1; tick(); expect_mode(3'd2, "R10");
    irq_pend[1] = 1; tick(); irq_pend = '0; expect_mode(3'd0, "R10");

    // R8: standby only leaves by reset
    deep_sel = 1; standby_sel = 1; wfi_req = 1; tick(); expect_mode(3'd5, "R8");
    irq_pend = '1; wake_evt = 1; idle(3); irq_pend = '0; expect_mode(3'd5, "R8");
    deep_sel = 0; standby_sel = 0;
    do_reset(); expect_mode(3'd0, "R8");

    // mixed random phase compared every cycle against the reference
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      r = $urandom;
      wfi_req       = (r[2:0] == 3'd0);
      wfe_req       = (r[5:3] == 3'd0);
      exc_ret       = (r[8:6] == 3'd0);
      sleep_on_exit = r[9];
      if (r[12:10] == 3'd0) begin
        lp_reg_sel = r[13]; lp_run_sel = r[14]; deep_sel = r[15];
        standby_sel = r[16] & r[17];
      end
      irq_pend = (r[20:18] == 3'd0) ? (32'd1 << r[25:21]) : '0;
      wake_evt = (r[28:26] == 3'd0);
      if (r[31:29] == 3'd0 && (c % 50 == 0)) do_reset();
      else tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule